// File: doc/BRIEF.md
# PS/2 Device-Side Command Receiver

This block sits on the peripheral end of a two-wire PS/2 link and takes in one command byte from the host. Both wires are open-drain. The block never drives a wire high. It only asserts pull-low enables, and it reads the wire levels back through a two-flop synchronizer. The host asks to send by pulling DATA low while CLK is free. The block then generates every clock pulse of the frame itself. Each phase is `HALF_CYCLES` reference cycles long, which is 720 cycles (30 µs) at 24 MHz. It samples one bit at the end of each high phase. After the frame it pulls DATA low for one more clock to acknowledge.

The frame has a start bit, eight data bits sent least significant bit first, an odd-parity bit and a stop bit. If the stop bit reads low, the block keeps clocking until the host lets DATA go high. It then acknowledges and flags that a resend must be requested. A host that holds CLK low blocks a new frame from starting, and doing so in the middle of a frame aborts that frame. At the end of every completed frame the block gives a one-cycle valid strobe, together with the byte, a parity-error flag and a resend-request flag. Sending bytes to the host and interpreting commands are done elsewhere.

The controller is one state machine with these states: `ST_IDLE`, `ST_SETTLE`, `ST_BIT_LO`, `ST_BIT_HI`, `ST_XTRA_LO`, `ST_XTRA_HI`, `ST_ACK_LO`, `ST_ACK_HI` and `ST_GAP`. Its transitions are:
- IDLE→SETTLE when CLK is high and DATA is low.
- SETTLE→BIT_LO when the request still stands after one phase; otherwise SETTLE→IDLE.
- BIT_LO→BIT_HI.
- BIT_HI→BIT_LO for clocks 1 to 9.
- BIT_HI→ACK_LO when the stop bit reads high at clock 10.
- BIT_HI→XTRA_LO when the stop bit reads low at clock 10.
- XTRA_LO→XTRA_HI.
- XTRA_HI→XTRA_LO while DATA stays low, and XTRA_HI→ACK_LO once DATA is high.
- BIT_HI→IDLE or XTRA_HI→IDLE when CLK is found held low (abort).
- ACK_LO→ACK_HI.
- ACK_HI→GAP, raising the strobe.
- GAP→IDLE.

Every state lasts exactly one phase, except IDLE.

Top module: `ps2_cmd_rx`

## Requirements
- R1: While in reset and after it, both pull-low enables are 0, and the valid strobe, byte, parity-error and resend outputs are 0.
- R2: A host request is DATA low while CLK is high in idle. After one settle phase the block asserts the CLK pull-low enable for exactly `HALF_CYCLES` cycles per clock pulse, with high phases of the same length between pulses.
- R3: While the host holds CLK low, a low DATA line starts no frame and the CLK pull-low enable stays 0. Once CLK is released with DATA still low, a normal frame follows.
- R4: Each bit is sampled at the end of a CLK high phase. Clocks 1 to 8 carry data bits 0 to 7 (LSB first), clock 9 carries parity and clock 10 carries the stop bit. The strobe presents the data bits as `rx_byte_o`.
- R5: Parity is odd over the 8 data bits plus the parity bit. On a mismatch, `rx_parity_err_o` and `rx_resend_o` are both 1 at the strobe.
- R6: When the stop bit reads high, clock 11 is the acknowledge. The DATA pull-low enable rises together with the CLK pull-low enable of clock 11 and holds through that clock's high phase. It is released before the strobe.
- R7: When the stop bit reads low, the block generates extra clocks until a high phase samples DATA high, then acknowledges. A frame with k extra clocks has 11+k clock pulses, and its strobe carries `rx_resend_o`=1.
- R8: `rx_valid_o` is a one-cycle pulse, once per completed frame, raised at the end of the acknowledge high phase. The byte and flags hold until the next strobe.
- R9: A host holding CLK low at the end of a high phase aborts the frame. Both enables are released and no strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (24 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_i | input | 1 | Level of the shared CLK wire |
| ps2_data_i | input | 1 | Level of the shared DATA wire |
| ps2_clk_pull_o | output | 1 | 1 = pull the CLK wire low |
| ps2_data_pull_o | output | 1 | 1 = pull the DATA wire low |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe at the end of a frame |
| rx_parity_err_o | output | 1 | Parity mismatch on the last frame |
| rx_resend_o | output | 1 | A resend must be requested (parity or stop error) |

## Verification
The bench builds the block with `HALF_CYCLES` = 8 and two synchronizer stages, so a frame takes a few hundred cycles instead of thousands. This makes it practical to run a series of frames in one run: good frames, a parity error, late stop bits with one and three extra clocks, an inhibit-then-release start and a mid-frame abort. At this small phase the two-cycle synchronizer delay is a large fraction of each phase. That exposes any sampling or release decision that reads a stale wire level. The default of 720 is only elaborated.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

    // Clock pulses in a regular frame before the acknowledge clock.
    localparam int FRAME_CLKS = 10;
    // Bits shifted into the receive register: 8 data plus parity.
    localparam int SHIFT_BITS = 9;
    localparam int BITCNT_W   = $clog2(FRAME_CLKS + 1);

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_SETTLE  = 4'd1,
        ST_BIT_LO  = 4'd2,
        ST_BIT_HI  = 4'd3,
        ST_XTRA_LO = 4'd4,
        ST_XTRA_HI = 4'd5,
        ST_ACK_LO  = 4'd6,
        ST_ACK_HI  = 4'd7,
        ST_GAP     = 4'd8
    } rx_state_e;

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_i,
    output logic [WIDTH-1:0] line_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Idle wires float high, so the chain resets to ones.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '1;
                else        stage_q[s] <= line_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '1;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign line_o = stage_q[STAGES-1];

endmodule

// File: rtl/ps2_phase_timer.sv
module ps2_phase_timer #(
    parameter int HALF_CYCLES = 720
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic expire_o
);

    localparam int CNT_W = $clog2(HALF_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (clr_i)     cnt_q <= '0;
        else if (!expire_o) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/ps2_rx_shift.sv
module ps2_rx_shift
    import ps2_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       shift_i,
    input  logic       bit_i,
    output logic [7:0] byte_o,
    output logic       parity_ok_o
);

    logic [SHIFT_BITS-1:0] sr_q;

    // Bits arrive LSB first, so each new bit enters at the top.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sr_q <= '0;
        else if (clr_i)   sr_q <= '0;
        else if (shift_i) sr_q <= {bit_i, sr_q[SHIFT_BITS-1:1]};
    end

    assign byte_o      = sr_q[7:0];
    assign parity_ok_o = ^sr_q;

endmodule

// File: rtl/ps2_cmd_rx.sv
module ps2_cmd_rx
    import ps2_rx_pkg::*;
#(
    parameter int HALF_CYCLES = 720,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_i,
    input  logic       ps2_data_i,
    output logic       ps2_clk_pull_o,
    output logic       ps2_data_pull_o,
    output logic [7:0] rx_byte_o,
    output logic       rx_valid_o,
    output logic       rx_parity_err_o,
    output logic       rx_resend_o
);

    localparam logic [BITCNT_W-1:0] STOP_IDX = BITCNT_W'(FRAME_CLKS - 1);
    localparam logic [BITCNT_W-1:0] SHIFT_LIM = BITCNT_W'(SHIFT_BITS);

    rx_state_e state_q, state_n;

    logic       clk_s, data_s;
    logic [1:0] sync_out;
    logic       expire, tmr_clr;
    logic       shift_en, shift_clr;
    logic [7:0] sh_byte;
    logic       sh_par_ok;
    logic [BITCNT_W-1:0] bitcnt_q;
    logic       stop_err_q;
    logic       strobe;

    ps2_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i ({ps2_clk_i, ps2_data_i}),
        .line_o (sync_out)
    );
    assign clk_s  = sync_out[1];
    assign data_s = sync_out[0];

    ps2_phase_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tmr_clr),
        .expire_o (expire)
    );

    ps2_rx_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (shift_clr),
        .shift_i     (shift_en),
        .bit_i       (data_s),
        .byte_o      (sh_byte),
        .parity_ok_o (sh_par_ok)
    );

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clk_s && !data_s) state_n = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (expire) state_n = (clk_s && !data_s) ? ST_BIT_LO : ST_IDLE;
            end
            ST_BIT_LO: begin
                if (expire) state_n = ST_BIT_HI;
            end
            ST_BIT_HI: begin
                if (expire) begin
                    if (!clk_s)                    state_n = ST_IDLE;
                    else if (bitcnt_q != STOP_IDX) state_n = ST_BIT_LO;
                    else if (data_s)               state_n = ST_ACK_LO;
                    else                           state_n = ST_XTRA_LO;
                end
            end
            ST_XTRA_LO: begin
                if (expire) state_n = ST_XTRA_HI;
            end
            ST_XTRA_HI: begin
                if (expire) begin
                    if (!clk_s)      state_n = ST_IDLE;
                    else if (data_s) state_n = ST_ACK_LO;
                    else             state_n = ST_XTRA_LO;
                end
            end
            ST_ACK_LO: begin
                if (expire) state_n = ST_ACK_HI;
            end
            ST_ACK_HI: begin
                if (expire) state_n = ST_GAP;
            end
            ST_GAP: begin
                if (expire) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Output decode: line enables follow the state directly
    always_comb begin
        ps2_clk_pull_o  = 1'b0;
        ps2_data_pull_o = 1'b0;
        unique case (state_q)
            ST_BIT_LO, ST_XTRA_LO: ps2_clk_pull_o = 1'b1;
            ST_ACK_LO: begin
                ps2_clk_pull_o  = 1'b1;
                ps2_data_pull_o = 1'b1;
            end
            ST_ACK_HI: ps2_data_pull_o = 1'b1;
            default: ;
        endcase
    end

    assign tmr_clr   = (state_n != state_q);
    assign shift_clr = (state_q == ST_SETTLE);
    assign shift_en  = (state_q == ST_BIT_HI) && expire && clk_s && (bitcnt_q < SHIFT_LIM);
    assign strobe    = (state_q == ST_ACK_HI) && expire;

    // Clock counter and stop-error memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q   <= '0;
            stop_err_q <= 1'b0;
        end else if (state_q == ST_SETTLE) begin
            bitcnt_q   <= '0;
            stop_err_q <= 1'b0;
        end else begin
            if (state_q == ST_BIT_HI && expire) bitcnt_q <= bitcnt_q + 1'b1;
            if (state_n == ST_XTRA_LO)          stop_err_q <= 1'b1;
        end
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid_o      <= 1'b0;
            rx_byte_o       <= '0;
            rx_parity_err_o <= 1'b0;
            rx_resend_o     <= 1'b0;
        end else begin
            rx_valid_o <= strobe;
            if (strobe) begin
                rx_byte_o       <= sh_byte;
                rx_parity_err_o <= !sh_par_ok;
                rx_resend_o     <= !sh_par_ok || stop_err_q;
            end
        end
    end

endmodule

// File: rtl/ps2_cmd_rx_chk.sv
module ps2_cmd_rx_chk #(
    parameter int HALF_CYCLES = 720
) (
    input logic clk,
    input logic rst_n,
    input logic ps2_clk_pull_o,
    input logic ps2_data_pull_o,
    input logic rx_valid_o,
    input logic rx_parity_err_o,
    input logic rx_resend_o
);

    localparam int LW = $clog2(HALF_CYCLES + 2) + 1;

    logic [LW-1:0] lo_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              lo_len_q <= '0;
        else if (ps2_clk_pull_o) lo_len_q <= lo_len_q + 1'b1;
        else                     lo_len_q <= '0;
    end

    assert_clk_low_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ps2_clk_pull_o) |-> (lo_len_q == LW'(HALF_CYCLES)));

    assert_ack_with_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ps2_data_pull_o) |-> $rose(ps2_clk_pull_o));

    assert_lines_free_at_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (!ps2_data_pull_o && !ps2_clk_pull_o));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_parity_resend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && rx_parity_err_o) |-> rx_resend_o);

endmodule

bind ps2_cmd_rx ps2_cmd_rx_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ps2_clk_pull_o  (ps2_clk_pull_o),
    .ps2_data_pull_o (ps2_data_pull_o),
    .rx_valid_o      (rx_valid_o),
    .rx_parity_err_o (rx_parity_err_o),
    .rx_resend_o     (rx_resend_o)
);

// File: tb/ps2_cmd_rx_test.sv
module ps2_cmd_rx_test;

    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_clk_lo = 1'b0;
    logic host_data_lo = 1'b0;

    logic       clk_pull, data_pull;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_perr, rx_resend;

    wire clk_line  = ~(host_clk_lo | clk_pull);
    wire data_line = ~(host_data_lo | data_pull);

    int n_chk  = 0;
    int n_fail = 0;
    int falls  = 0;
    int pull_rises = 0;
    int lo_run = 0;
    int last_lo = 0;
    logic prev_valid = 1'b0;

    typedef struct {
        logic [7:0] b;
        logic       perr;
        logic       rs;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    ps2_cmd_rx #(.HALF_CYCLES(HALF), .SYNC_STAGES(2)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ps2_clk_i       (clk_line),
        .ps2_data_i      (data_line),
        .ps2_clk_pull_o  (clk_pull),
        .ps2_data_pull_o (data_pull),
        .rx_byte_o       (rx_byte),
        .rx_valid_o      (rx_valid),
        .rx_parity_err_o (rx_perr),
        .rx_resend_o     (rx_resend)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    always @(negedge clk_line) if (!host_clk_lo) falls++;
    always @(posedge clk_pull) pull_rises++;

    // Length of each device clock pulse, sampled away from the active edge
    always @(negedge clk) begin
        if (clk_pull) lo_run++;
        else if (lo_run != 0) begin
            last_lo = lo_run;
            lo_run  = 0;
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && prev_valid)
                check(1'b0, "R8", "strobe longer than one cycle", 2, 1);
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rx_byte == e.b, "R4", "byte", rx_byte, e.b);
                    check(rx_perr == e.perr, "R5", "parity flag", rx_perr, e.perr);
                    check(rx_resend == e.rs, "R7", "resend flag", rx_resend, e.rs);
                end
            end
            prev_valid = rx_valid;
        end
    end

    // Host side of one host-to-device frame; extra = clocks the stop bit stays low
    task automatic host_send(input logic [7:0] b, input bit bad_par, input int extra);
        exp_t e;
        logic par;
        par = ~(^b) ^ bad_par;
        e.b = b; e.perr = bad_par; e.rs = bad_par || (extra > 0);
        exp_q.push_back(e);
        falls = 0;
        host_data_lo = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk_line);
            host_data_lo = ~b[k];
        end
        @(negedge clk_line);
        host_data_lo = ~par;
        @(negedge clk_line);
        host_data_lo = (extra > 0);
        for (int j = 1; j <= extra; j++) begin
            @(negedge clk_line);
            if (j == extra) host_data_lo = 1'b0;
        end
        @(negedge clk_line);
        repeat (2) @(negedge clk);
        check(data_line == 1'b0, "R6", "acknowledge drives DATA low", data_line, 0);
        @(posedge data_line);
        repeat (3 * HALF) @(negedge clk);
        check(falls == 11 + extra, "R7", "clock pulses in frame", falls, 11 + extra);
        check(last_lo == HALF, "R2", "clock low length", last_lo, HALF);
        check(exp_q.size() == 0, "R8", "strobe count after frame", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(clk_pull == 0 && data_pull == 0, "R1", "pull enables in reset",
              {clk_pull, data_pull}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(clk_pull == 0 && data_pull == 0 && rx_valid == 0, "R1",
              "idle after reset", {clk_pull, data_pull, rx_valid}, 0);
        check(rx_byte == 0 && rx_perr == 0 && rx_resend == 0, "R1",
              "result outputs after reset", {rx_byte, rx_perr, rx_resend}, 0);

        // R4: varied data patterns
        host_send(8'hA5, 1'b0, 0);
        host_send(8'h00, 1'b0, 0);
        host_send(8'hFF, 1'b0, 0);
        // R5: wrong parity
        host_send(8'h3C, 1'b1, 0);
        // R8: flags of the last frame held until next strobe
        check(rx_perr == 1 && rx_resend == 1 && rx_byte == 8'h3C, "R8",
              "flags held after strobe", {rx_perr, rx_resend}, 3);
        // R7: late stop bit
        host_send(8'h81, 1'b0, 1);
        host_send(8'h5A, 1'b0, 3);

        // R3: inhibit, then release with DATA still low
        host_clk_lo  = 1'b1;
        host_data_lo = 1'b1;
        pull_rises   = 0;
        repeat (6 * HALF) @(negedge clk);
        check(pull_rises == 0, "R3", "no clock while inhibited", pull_rises, 0);
        host_clk_lo = 1'b0;
        host_send(8'hC3, 1'b0, 0);

        // R9: abort in the first high phase
        host_data_lo = 1'b1;
        @(negedge clk_line);
        host_data_lo = 1'b0;
        @(posedge clk_line);
        repeat (2) @(negedge clk);
        host_clk_lo = 1'b1;
        repeat (3 * HALF) @(negedge clk);
        check(clk_pull == 0 && data_pull == 0, "R9", "lines released on abort",
              {clk_pull, data_pull}, 0);
        pull_rises = 0;
        host_clk_lo = 1'b0;
        repeat (6 * HALF) @(negedge clk);
        check(pull_rises == 0, "R9", "no clocks after abort", pull_rises, 0);
        check(exp_q.size() == 0, "R9", "no pending strobe", exp_q.size(), 0);

        // R2: a fresh frame after the abort still works
        host_send(8'h69, 1'b0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule